// File: doc/BRIEF.md
# Configurable Audio Serial Data Transmitter

This block turns a stream of stereo PCM sample pairs into a single serial data line. It works as a slave: an external master supplies the bit clock and the frame-sync (channel) clock, and the block only decides which bit to put on the line in each bit period. Four framings are available: left-justified, right-justified, I2S and a DSP/TDM-style short-pulse framing. In the DSP framing the left word is sent and the right word follows at once.

One polarity control changes meaning with the framing. In the left/right framings it swaps which frame-sync level carries which channel. In the DSP framing it chooses whether the MSB goes out one or two bit periods after the frame-sync rising edge. Samples arrive on a valid/ready handshake and are held in a one-deep holding register. A new pair is taken up at each frame start. If no pair is waiting at that point, the frame carries zeros and a sticky underrun flag is raised.

All state is updated on the falling edge of the bit clock, so the line is stable when the receiver samples it on the rising edge. The first bit after a frame-sync transition is steered straight from the frame-sync input, so it is already valid at the first rising edge.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is held, `sdata_o` is 0, `smp_ready_o` is 1 and `urun_o` is 0. Reset is asserted asynchronously and released on the second falling bit-clock edge after `rst_ni` rises.
- R2: Left-justified (`fmt_i`=0): the word MSB is on the line during the bit period in which frame sync changes level, so it is valid at the first rising edge after the change. The remaining bits follow MSB first, one per bit period, and every bit changes only after a falling edge.
- R3: I2S (`fmt_i`=2): the MSB comes one bit period later than in left-justified, and the first bit period after a change is 0. With `pol_i`=0 the left word goes out while frame sync is low; with `pol_i`=1 it goes out while frame sync is high.
- R4: Right-justified (`fmt_i`=1): the word is placed so that its LSB is in bit period SLOT_BITS-1 counted from the frame-sync change. Earlier periods carry 0.
- R5: In the left- and right-justified framings, `pol_i`=0 sends the left word while frame sync is high and the right word while it is low. `pol_i`=1 swaps these levels.
- R6: DSP (`fmt_i`=3) with `pol_i`=0: a frame starts on each frame-sync rising edge, regardless of the polarity control. The left MSB is valid at the first rising bit-clock edge after that edge, the right word follows the left LSB directly, and all later bit periods carry 0.
- R7: DSP with `pol_i`=1: the whole frame is delayed by one bit period, so the MSB is valid at the second rising edge. A falling edge of frame sync has no effect on the output.
- R8: Word length `wlen_i` picks 16, 20, 24 or 32 bits (codes 0..3). A word is taken from the low bits of the sample input, and bit periods of a slot beyond the word are 0.
- R9: If no pair is held at a frame start, that frame sends zeros in both channels and `urun_o` goes to 1 after the falling edge that ends that bit period. It stays at 1 until `urun_clr_i` is sampled high on a falling edge with no new underrun in the same period.
- R10: `smp_ready_o` is 1 exactly when the holding register is empty. A pair offered while it is full is dropped. The held pair is used for the frame that starts next, and the register empties at that frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock from the link master; state updates on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync / channel clock from the link master |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S, 3 DSP |
| pol_i | input | 1 | Channel phasing (left/right framings) or MSB delay (DSP) |
| wlen_i | input | 2 | Word length code: 16, 20, 24, 32 bits |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Holding register empty, pair will be taken |
| smp_left_i | input | MAX_WL | Left sample, right-aligned in the field |
| smp_right_i | input | MAX_WL | Right sample, right-aligned in the field |
| urun_clr_i | input | 1 | Clears the underrun flag |
| urun_o | output | 1 | Sticky underrun flag |
| sdata_o | output | 1 | Serial data line |

## Verification
The bench builds the block with its defaults: 32-bit sample fields, a 32-period channel slot and a two-stage reset release. With a 32-period slot, a 32-bit left-justified word fills its half exactly and a 20-bit right-justified word starts twelve periods in, so both ends of the slot are checked. The DSP runs use frames of 40 and 56 periods, and one of them holds frame sync high for several periods, so the back-to-back right word, the zero tail and the ignored falling edge can all be seen. Each framing runs several frames after its own reset, covering a missed sample, a double offer and a flag clear.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_RJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // word length in bits for a length code
  function automatic int wl_of(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/atx_rst_sync.sv
module atx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/atx_fs_track.sv
module atx_fs_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             dsp_i,
  output logic             chg_o,
  output logic             rise_o,
  output logic             restart_o,
  output logic [CNT_W-1:0] slot_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             fs_q, fs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    chg_o     = fsync_i ^ fs_q;
    rise_o    = fsync_i & ~fs_q;
    restart_o = dsp_i ? rise_o : chg_o;
    slot_o    = restart_o ? '0 : cnt_q;
    fs_d      = fsync_i;
    if (restart_o)            cnt_d = CNT_W'(1);
    else if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      cnt_q <= CNT_SAT;
    end else begin
      fs_q  <= fs_d;
      cnt_q <= cnt_d;
    end
  end

  // R6: a restart always leaves the next period at index 1 unless it restarts again
  p_restart_next_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    restart_o |=> (restart_o || slot_o == CNT_W'(1)));

endmodule

// File: rtl/atx_sample_hold.sv
module atx_sample_hold #(
  parameter int MAX_WL = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [MAX_WL-1:0] left_i,
  input  logic [MAX_WL-1:0] right_i,
  input  logic              start_i,
  input  logic              clr_i,
  output logic              urun_o,
  output logic [MAX_WL-1:0] word_l_o,
  output logic [MAX_WL-1:0] word_r_o
);

  logic              pend_q, pend_d;
  logic [MAX_WL-1:0] pl_q, pr_q, al_q, ar_q;
  logic              urun_q, urun_d;
  logic              take, ld_act;

  always_comb begin
    ready_o = ~pend_q;
    take    = valid_i & ready_o;
    ld_act  = start_i;
    // at a frame start the pair in flight is the held one (or silence)
    word_l_o = start_i ? (pend_q ? pl_q : '0) : al_q;
    word_r_o = start_i ? (pend_q ? pr_q : '0) : ar_q;
    pend_d = pend_q;
    if (start_i) pend_d = 1'b0;
    if (take)    pend_d = 1'b1;
    if (start_i && !pend_q) urun_d = 1'b1;
    else if (clr_i)         urun_d = 1'b0;
    else                    urun_d = urun_q;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      urun_q <= 1'b0;
      pl_q   <= '0;
      pr_q   <= '0;
      al_q   <= '0;
      ar_q   <= '0;
    end else begin
      pend_q <= pend_d;
      urun_q <= urun_d;
      if (take) begin
        pl_q <= left_i;
        pr_q <= right_i;
      end
      if (ld_act) begin
        al_q <= word_l_o;
        ar_q <= word_r_o;
      end
    end
  end

  assign urun_o = urun_q;

  p_urun_sticky_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (urun_o && !clr_i) |=> urun_o);
  p_urun_set_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> urun_o);
  p_take_fills_r10: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
  p_start_empties_r10: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (start_i && !ready_o) |=> ready_o);

endmodule

// File: rtl/atx_bit_pick.sv
module atx_bit_pick #(
  parameter int MAX_WL    = 32,
  parameter int SLOT_BITS = 32,
  parameter int CNT_W     = 8
) (
  input  atx_pkg::fmt_e     fmt_i,
  input  logic              pol_i,
  input  logic [1:0]        wlen_i,
  input  logic [CNT_W-1:0]  slot_i,
  input  logic              left_lvl_i,
  input  logic [MAX_WL-1:0] word_l_i,
  input  logic [MAX_WL-1:0] word_r_i,
  output logic              bit_o
);
  import atx_pkg::*;

  localparam int IDX_W = $clog2(MAX_WL);

  int                wl, dly, pos;
  logic              use_left;
  logic [MAX_WL-1:0] word;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    wl       = wl_of(wlen_i);
    use_left = left_lvl_i;
    idx      = '0;
    bit_o    = 1'b0;
    unique case (fmt_i)
      FMT_LJ:  dly = 0;
      FMT_RJ:  dly = SLOT_BITS - wl;
      FMT_I2S: dly = 1;
      default: dly = int'(pol_i);
    endcase
    pos = int'(slot_i) - dly;
    if (fmt_i == FMT_DSP) begin
      if (pos >= wl) begin
        use_left = 1'b0;
        pos      = pos - wl;
      end else begin
        use_left = 1'b1;
      end
    end
    word = use_left ? word_l_i : word_r_i;
    if (pos >= 0 && pos < wl) begin
      idx   = IDX_W'(wl - 1 - pos);
      bit_o = word[idx];
    end
  end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int MAX_WL     = 32,
  parameter int SLOT_BITS  = 32,
  parameter int RST_STAGES = 2
) (
  input  logic              bclk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [1:0]        fmt_i,
  input  logic              pol_i,
  input  logic [1:0]        wlen_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [MAX_WL-1:0] smp_left_i,
  input  logic [MAX_WL-1:0] smp_right_i,
  input  logic              urun_clr_i,
  output logic              urun_o,
  output logic              sdata_o
);
  import atx_pkg::*;

  localparam int CNT_W = $clog2(2 * MAX_WL + SLOT_BITS + 2) + 1;

  fmt_e              fmt;
  logic              rst_s, chg, rise, restart, left_lvl, frame_go;
  logic [CNT_W-1:0]  slot;
  logic [MAX_WL-1:0] word_l, word_r;

  assign fmt = fmt_e'(fmt_i);

  atx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (bclk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_s)
  );

  atx_fs_track #(.CNT_W(CNT_W)) u_fs (
    .clk_i    (bclk_i),
    .rst_ni   (rst_s),
    .fsync_i  (fsync_i),
    .dsp_i    (fmt == FMT_DSP),
    .chg_o    (chg),
    .rise_o   (rise),
    .restart_o(restart),
    .slot_o   (slot)
  );

  // level that carries the left channel flips between justified and I2S framings
  always_comb begin
    left_lvl = (fsync_i == ((fmt == FMT_I2S) ? pol_i : ~pol_i));
    frame_go = (fmt == FMT_DSP) ? rise : (chg & left_lvl);
  end

  atx_sample_hold #(.MAX_WL(MAX_WL)) u_hold (
    .clk_i   (bclk_i),
    .rst_ni  (rst_s),
    .valid_i (smp_valid_i),
    .ready_o (smp_ready_o),
    .left_i  (smp_left_i),
    .right_i (smp_right_i),
    .start_i (frame_go),
    .clr_i   (urun_clr_i),
    .urun_o  (urun_o),
    .word_l_o(word_l),
    .word_r_o(word_r)
  );

  atx_bit_pick #(.MAX_WL(MAX_WL), .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) u_pick (
    .fmt_i     (fmt),
    .pol_i     (pol_i),
    .wlen_i    (wlen_i),
    .slot_i    (slot),
    .left_lvl_i(left_lvl),
    .word_l_i  (word_l),
    .word_r_i  (word_r),
    .bit_o     (sdata_o)
  );

  p_lj_pad_r8: assert property (@(negedge bclk_i) disable iff (!rst_s)
    (fmt == FMT_LJ && int'(slot) >= wl_of(wlen_i)) |-> !sdata_o);
  p_dsp_tail_r6: assert property (@(negedge bclk_i) disable iff (!rst_s)
    (fmt == FMT_DSP && int'(slot) >= 2 * wl_of(wlen_i) + int'(pol_i)) |-> !sdata_o);
  p_dsp_lead_r7: assert property (@(negedge bclk_i) disable iff (!rst_s)
    (fmt == FMT_DSP && pol_i && restart) |-> !sdata_o);
  p_i2s_lead_r3: assert property (@(negedge bclk_i) disable iff (!rst_s)
    (fmt == FMT_I2S && chg) |-> !sdata_o);

endmodule

// File: tb/tb_aud_ser_tx.sv
module tb_aud_ser_tx;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT_BITS  = 32;
  localparam int WMAX       = 32;

  logic            bclk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fsync = 1'b0;
  logic            pol = 1'b0;
  logic            valid = 1'b0;
  logic            clr = 1'b0;
  logic [1:0]      fmt = 2'd0;
  logic [1:0]      wlen = 2'd0;
  logic [WMAX-1:0] dl = '0;
  logic [WMAX-1:0] dr = '0;
  logic            ready, urun, sd;

  aud_ser_tx #(.MAX_WL(WMAX), .SLOT_BITS(SLOT_BITS), .RST_STAGES(2)) dut (
    .bclk_i     (bclk),
    .rst_ni     (rst_n),
    .fsync_i    (fsync),
    .fmt_i      (fmt),
    .pol_i      (pol),
    .wlen_i     (wlen),
    .smp_valid_i(valid),
    .smp_ready_o(ready),
    .smp_left_i (dl),
    .smp_right_i(dr),
    .urun_clr_i (clr),
    .urun_o     (urun),
    .sdata_o    (sd)
  );

  always #(CLK_PERIOD / 2) bclk = ~bclk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R2";

  // reference model state
  logic [WMAX-1:0] q_l[$];
  logic [WMAX-1:0] q_r[$];
  logic [WMAX-1:0] cur_l = '0;
  logic [WMAX-1:0] cur_r = '0;
  bit              m_prev = 1'b0;
  bit              m_urun = 1'b0;
  int              m_j = 1000;

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit left_level();
    if (fmt == 2'd2) return pol;     // I2S: pol 0 -> left on low
    return ~pol;                      // justified: pol 0 -> left on high
  endfunction

  function automatic int wbits();
    case (wlen)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic exp_bit(int j, bit is_left);
    int wl, p;
    logic [WMAX-1:0] w;
    wl = wbits();
    if (fmt == 2'd3) begin
      p = j - (pol ? 1 : 0);
      if (p < wl) w = cur_l;
      else if (p < 2 * wl) begin
        w = cur_r;
        p = p - wl;
      end else return 1'b0;
    end else begin
      if (fmt == 2'd0)      p = j;
      else if (fmt == 2'd1) p = j - (SLOT_BITS - wl);
      else                  p = j - 1;
      w = is_left ? cur_l : cur_r;
    end
    if (p < 0 || p >= wl) return 1'b0;
    return w[wl-1-p];
  endfunction

  task automatic slot(bit fs, bit push, logic [WMAX-1:0] l, logic [WMAX-1:0] r, bit c);
    bit   restart, start, rdy, is_left;
    logic e;
    @(negedge bclk);
    #1;
    fsync = fs; valid = push; dl = l; dr = r; clr = c;
    restart = (fmt == 2'd3) ? (fs && !m_prev) : (fs != m_prev);
    m_j     = restart ? 0 : m_j + 1;
    m_prev  = fs;
    is_left = (fs == left_level());
    start   = restart && ((fmt == 2'd3) || is_left);
    rdy     = (q_l.size() == 0);
    if (start) begin
      if (!rdy) begin
        cur_l = q_l.pop_front();
        cur_r = q_r.pop_front();
      end else begin
        cur_l = '0;
        cur_r = '0;
      end
    end
    e = exp_bit(m_j, is_left);
    @(posedge bclk);
    #1;
    chk(cur_req, "sdata", sd, e);
    chk("R10", "ready", ready, rdy);
    chk("R9", "underrun", urun, m_urun);
    if (push && rdy) begin
      q_l.push_back(l);
      q_r.push_back(r);
    end
    if (start && rdy) m_urun = 1'b1;
    else if (c)       m_urun = 1'b0;
  endtask

  task automatic do_reset(logic [1:0] f, bit p, logic [1:0] w);
    @(negedge bclk);
    #1;
    rst_n = 1'b0; fsync = 1'b0; valid = 1'b0; clr = 1'b0;
    fmt = f; pol = p; wlen = w;
    @(posedge bclk);
    #1;
    chk("R1", "sdata in reset", sd, 1'b0);
    chk("R1", "ready in reset", ready, 1'b1);
    chk("R1", "underrun in reset", urun, 1'b0);
    @(negedge bclk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(negedge bclk);
    q_l.delete(); q_r.delete();
    cur_l = '0; cur_r = '0;
    m_prev = 1'b0; m_urun = 1'b0; m_j = 1000;
  endtask

  task automatic lr_frame(int half, bit push, logic [WMAX-1:0] l, logic [WMAX-1:0] r,
                          bit clr_at, bit dbl);
    bit lv;
    lv = left_level();
    for (int i = 0; i < 2 * half; i++) begin
      bit              fs, pu;
      logic [WMAX-1:0] a, b;
      fs = (i < half) ? lv : ~lv;
      pu = push && (i == 2);
      a = l; b = r;
      if (dbl && i == 4) begin
        pu = 1'b1; a = ~l; b = ~r;
      end
      slot(fs, pu, a, b, clr_at && (i == 3));
    end
  endtask

  task automatic dsp_frame(int len, int hi, bit push, logic [WMAX-1:0] l,
                           logic [WMAX-1:0] r, bit clr_at);
    for (int i = 0; i < len; i++) begin
      slot(i < hi, push && (i == 2), l, r, clr_at && (i == 3));
    end
  endtask

  task automatic run_lr(int half);
    lr_frame(half, 1'b1, 32'hA5C3_96F1, 32'h3C5A_E10F, 1'b0, 1'b0);
    lr_frame(half, 1'b1, 32'h1234_5678, 32'hFEDC_BA98, 1'b0, 1'b1);
    lr_frame(half, 1'b0, '0, '0, 1'b1, 1'b0);
    lr_frame(half, 1'b1, 32'h8001_7FFE, 32'h0F0F_F0F0, 1'b0, 1'b0);
    lr_frame(half, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic run_dsp(int len, int hi);
    dsp_frame(len, 1,  1'b1, 32'hC0DE_BEEF, 32'h5A5A_A5A5, 1'b0);
    dsp_frame(len, hi, 1'b1, 32'h8765_4321, 32'h0BAD_F00D, 1'b0);
    dsp_frame(len, 1,  1'b0, '0, '0, 1'b1);
    dsp_frame(len, hi, 1'b1, 32'hFFFF_0001, 32'h7777_8888, 1'b0);
    dsp_frame(len, 1,  1'b0, '0, '0, 1'b0);
  endtask

  initial begin
    // R2 and R8: left-justified, 16-bit words padded in a 32-period half
    cur_req = "R2 R8";
    do_reset(2'd0, 1'b0, 2'd0);
    run_lr(32);
    // R5: left-justified with swapped phasing, full 32-bit words
    cur_req = "R5 R2";
    do_reset(2'd0, 1'b1, 2'd3);
    run_lr(32);
    // R4: right-justified, 20-bit words end on the last period of the half
    cur_req = "R4";
    do_reset(2'd1, 1'b0, 2'd1);
    run_lr(32);
    // R3: I2S one-period delay, both phasings
    cur_req = "R3";
    do_reset(2'd2, 1'b0, 2'd2);
    run_lr(32);
    cur_req = "R3 R5";
    do_reset(2'd2, 1'b1, 2'd0);
    run_lr(24);
    // R6: DSP without extra delay, wide frame-sync pulse in some frames
    cur_req = "R6";
    do_reset(2'd3, 1'b0, 2'd0);
    run_dsp(40, 3);
    // R7: DSP with one-period delay, falling edge must not restart
    cur_req = "R7";
    do_reset(2'd3, 1'b1, 2'd2);
    run_dsp(56, 5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule